// File: doc/BRIEF.md
# Controller Data Bus Park and Termination Scheduler

This block sits in a memory controller that shares a bidirectional data bus with a double-data-rate SRAM. It runs on a clock whose period is one half of the memory clock, so every decision is made per half cycle. In each half cycle it picks one of three bus states. The controller drives a write-data beat, or it parks the bus at a constant low, or it releases the bus and turns on its own receive termination so that read data can arrive. The bus is never left undriven and unterminated.

Each accepted read command opens a termination window. The window is placed from the configured read latency plus a fixed round-trip flight offset, and it is widened by a lead guard band before the data and a trail guard band after it. Both guard bands are set in half-cycle units and can be kept short, so that the bus spends little time floating at mid-supply. Windows from reads that are close together merge into one interval. Write beats that fall inside a window are counted and then sent in order as soon as the window closes. An upstream write-data FIFO pops one beat for each half cycle in which the select output chooses write data.

Top module: `bus_park_sched`

## Requirements
- R1: While reset is held, and directly after it, drive_en_o=1, drive_sel_o=0 (0 means constant low, 1 means write data) and term_en_o=0.
- R2: In every half cycle exactly one of drive_en_o and term_en_o is 1, so the bus is never floating and never driven into the controller's own termination.
- R3: Let L = rd_lat + RT_OFS_HALF half cycles. When rd_cmd_i is sampled at clock edge E0, term_en_o is 1 after edges E(L-lead-1) up to and including E(L+BURST_HALF+trail-2), and it is 0 again after the next edge if no other read is open.
- R4: After reset the lead guard is 1 half cycle, the trail guard is 3 half cycles and rd_lat is 5 half cycles. With RT_OFS_HALF=1 and BURST_HALF=2, a read at E0 gives termination after edges E4 to E9.
- R5: When cfg_we is sampled high at an edge, lead, trail and rd_lat take the new values for reads sampled at later edges. When cfg_we is low they hold their values.
- R6: If the lead guard is L or more, it is clipped to L-1, so the window starts right after the edge that sampled the read.
- R7: Windows of reads that overlap or touch form one continuous termination interval, with no parked half cycle between them.
- R8: Between windows that do not touch, the bus returns to drive_en_o=1 with drive_sel_o=0.
- R9: A wr_valid_i pulse sampled at an edge gives drive_sel_o=1 for one half cycle directly after that edge, provided termination is off in that half cycle.
- R10: Write beats that would fall inside a termination window are held back. They are then sent in consecutive half cycles directly after the window closes, one for each pulse received.
- R11: At most WR_DEPTH write beats may be held back at once. A pulse that arrives while the count is full is a usage error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-cycle clock (twice the memory clock rate) |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Loads the three configuration fields |
| cfg_lead_i | input | GB_W | Lead guard band, half cycles |
| cfg_trail_i | input | GB_W | Trail guard band, half cycles |
| cfg_rd_lat_i | input | LAT_W | Read latency, half cycles |
| rd_cmd_i | input | 1 | A read command is issued in this half cycle |
| wr_valid_i | input | 1 | One write-data beat is ready upstream |
| drive_en_o | output | 1 | Controller output driver enable |
| drive_sel_o | output | 1 | 1 = drive write data, 0 = drive constant low |
| term_en_o | output | 1 | Controller receive termination enable |

## Verification
The hardest case to reach is a set of write beats that arrive during a window which is then stretched by a second, overlapping read. The held beats must survive the whole merged interval and then leave back to back. The stimulus table issues two reads three half cycles apart and injects write pulses before the window opens and in the middle of it. It checks that the early beat goes out at once and that the later two come out only after the merged window closes. The clipping of the lead guard is reached by loading a lead larger than the total latency and observing that termination rises right after the read is sampled.

// File: rtl/bps_pkg.sv
package bps_pkg;

    typedef enum logic {
        SEL_PARK_LOW = 1'b0,
        SEL_WDATA    = 1'b1
    } drv_sel_e;

    function automatic int unsigned bps_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/bps_cfg_regs.sv
module bps_cfg_regs #(
    parameter int unsigned GB_W       = 4,
    parameter int unsigned LAT_W      = 4,
    parameter int unsigned LEAD_DEF   = 1,
    parameter int unsigned TRAIL_DEF  = 3,
    parameter int unsigned RD_LAT_DEF = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [GB_W-1:0]  cfg_lead_i,
    input  logic [GB_W-1:0]  cfg_trail_i,
    input  logic [LAT_W-1:0] cfg_rd_lat_i,
    output logic [GB_W-1:0]  lead_o,
    output logic [GB_W-1:0]  trail_o,
    output logic [LAT_W-1:0] rd_lat_o
);

    typedef struct packed {
        logic [GB_W-1:0]  lead;
        logic [GB_W-1:0]  trail;
        logic [LAT_W-1:0] rd_lat;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            cfg_d.lead   = cfg_lead_i;
            cfg_d.trail  = cfg_trail_i;
            cfg_d.rd_lat = cfg_rd_lat_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.lead   <= GB_W'(LEAD_DEF);
            cfg_q.trail  <= GB_W'(TRAIL_DEF);
            cfg_q.rd_lat <= LAT_W'(RD_LAT_DEF);
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign lead_o   = cfg_q.lead;
    assign trail_o  = cfg_q.trail;
    assign rd_lat_o = cfg_q.rd_lat;

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(cfg_q)); // R5

endmodule

// File: rtl/bps_window_gen.sv
module bps_window_gen #(
    parameter int unsigned GB_W        = 4,
    parameter int unsigned LAT_W       = 4,
    parameter int unsigned RT_OFS_HALF = 1,
    parameter int unsigned BURST_HALF  = 2,
    parameter int unsigned TL_DEPTH    = 35
) (
    input  logic [GB_W-1:0]     lead_i,
    input  logic [GB_W-1:0]     trail_i,
    input  logic [LAT_W-1:0]    rd_lat_i,
    output logic [TL_DEPTH-1:0] mask_o
);

    localparam int unsigned IDX_W = $clog2(TL_DEPTH) + 2;

    logic [IDX_W-1:0] l_tot;
    logic [IDX_W-1:0] lead_eff;
    logic [IDX_W-1:0] lo_idx;
    logic [IDX_W-1:0] hi_idx;

    always_comb begin
        l_tot = IDX_W'(rd_lat_i) + IDX_W'(RT_OFS_HALF);
        if (l_tot == '0) begin
            l_tot = IDX_W'(1);
        end
        // a lead reaching back past the command is clipped
        if (IDX_W'(lead_i) >= l_tot) begin
            lead_eff = l_tot - IDX_W'(1);
        end else begin
            lead_eff = IDX_W'(lead_i);
        end
        lo_idx = l_tot - lead_eff - IDX_W'(1);
        hi_idx = l_tot + IDX_W'(BURST_HALF) + IDX_W'(trail_i) - IDX_W'(2);
        for (int i = 0; i < int'(TL_DEPTH); i++) begin
            mask_o[i] = (IDX_W'(i) >= lo_idx) && (IDX_W'(i) <= hi_idx);
        end
    end

endmodule

// File: rtl/bps_timeline.sv
module bps_timeline #(
    parameter int unsigned TL_DEPTH = 35
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_cmd_i,
    input  logic [TL_DEPTH-1:0] mask_i,
    output logic                busy_next_o,
    output logic                term_en_o
);

    // bit i of the state: termination wanted i half cycles after the current one
    typedef struct packed {
        logic [TL_DEPTH-1:0] slots;
    } tl_t;

    tl_t tl_d, tl_q;

    always_comb begin
        tl_d.slots = tl_q.slots >> 1;
        if (rd_cmd_i) begin
            tl_d.slots = tl_d.slots | mask_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tl_q <= '0;
        end else begin
            tl_q <= tl_d;
        end
    end

    assign busy_next_o = tl_d.slots[0];
    assign term_en_o   = tl_q.slots[0];

    AST_TERM_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_cmd_i && !tl_q.slots[1]) |=> !term_en_o); // R3

endmodule

// File: rtl/bps_wr_pacer.sv
module bps_wr_pacer #(
    parameter int unsigned WR_DEPTH = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_valid_i,
    input  logic busy_next_i,
    output logic drive_en_o,
    output logic drive_sel_o
);

    import bps_pkg::*;

    localparam int unsigned CNT_W = $clog2(WR_DEPTH + 1);

    typedef struct packed {
        logic [CNT_W-1:0] pend;
        logic             drv;
        drv_sel_e         sel;
    } pacer_t;

    pacer_t pc_d, pc_q;
    logic   issue;

    always_comb begin
        pc_d  = pc_q;
        issue = !busy_next_i && ((pc_q.pend != '0) || wr_valid_i);
        pc_d.pend = pc_q.pend + CNT_W'(wr_valid_i) - CNT_W'(issue);
        pc_d.drv  = !busy_next_i;
        pc_d.sel  = issue ? SEL_WDATA : SEL_PARK_LOW;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q.pend <= '0;
            pc_q.drv  <= 1'b1;
            pc_q.sel  <= SEL_PARK_LOW;
        end else begin
            pc_q <= pc_d;
        end
    end

    assign drive_en_o  = pc_q.drv;
    assign drive_sel_o = pc_q.sel;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_valid_i && (pc_q.pend == CNT_W'(WR_DEPTH)))); // R11

endmodule

// File: rtl/bus_park_sched.sv
module bus_park_sched #(
    parameter int unsigned GB_W        = 4,
    parameter int unsigned LAT_W       = 4,
    parameter int unsigned RT_OFS_HALF = 1,
    parameter int unsigned BURST_HALF  = 2,
    parameter int unsigned LEAD_DEF    = 1,
    parameter int unsigned TRAIL_DEF   = 3,
    parameter int unsigned RD_LAT_DEF  = 5,
    parameter int unsigned WR_DEPTH    = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [GB_W-1:0]  cfg_lead_i,
    input  logic [GB_W-1:0]  cfg_trail_i,
    input  logic [LAT_W-1:0] cfg_rd_lat_i,
    input  logic             rd_cmd_i,
    input  logic             wr_valid_i,
    output logic             drive_en_o,
    output logic             drive_sel_o,
    output logic             term_en_o
);

    localparam int unsigned TL_DEPTH = bps_pkg::bps_max(2,
        (1 << LAT_W) + RT_OFS_HALF + BURST_HALF + (1 << GB_W));

    logic [GB_W-1:0]     lead;
    logic [GB_W-1:0]     trail;
    logic [LAT_W-1:0]    rd_lat;
    logic [TL_DEPTH-1:0] win_mask;
    logic                busy_next;

    bps_cfg_regs #(
        .GB_W(GB_W), .LAT_W(LAT_W), .LEAD_DEF(LEAD_DEF),
        .TRAIL_DEF(TRAIL_DEF), .RD_LAT_DEF(RD_LAT_DEF)
    ) cfg_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we),
        .cfg_lead_i(cfg_lead_i), .cfg_trail_i(cfg_trail_i), .cfg_rd_lat_i(cfg_rd_lat_i),
        .lead_o(lead), .trail_o(trail), .rd_lat_o(rd_lat)
    );

    bps_window_gen #(
        .GB_W(GB_W), .LAT_W(LAT_W), .RT_OFS_HALF(RT_OFS_HALF),
        .BURST_HALF(BURST_HALF), .TL_DEPTH(TL_DEPTH)
    ) win_i (
        .lead_i(lead), .trail_i(trail), .rd_lat_i(rd_lat), .mask_o(win_mask)
    );

    bps_timeline #(
        .TL_DEPTH(TL_DEPTH)
    ) tl_i (
        .clk(clk), .rst_n(rst_n), .rd_cmd_i(rd_cmd_i), .mask_i(win_mask),
        .busy_next_o(busy_next), .term_en_o(term_en_o)
    );

    bps_wr_pacer #(
        .WR_DEPTH(WR_DEPTH)
    ) pacer_i (
        .clk(clk), .rst_n(rst_n), .wr_valid_i(wr_valid_i), .busy_next_i(busy_next),
        .drive_en_o(drive_en_o), .drive_sel_o(drive_sel_o)
    );

    AST_BUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(drive_en_o && term_en_o)); // R2
    AST_BUS_NEVER_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_en_o || term_en_o)); // R2
    AST_SEL_NEEDS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        drive_sel_o |-> drive_en_o); // R9

endmodule

// File: tb/bus_park_sched_tb.sv
module bus_park_sched_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_lead_i = '0;
    logic [3:0] cfg_trail_i = '0;
    logic [3:0] cfg_rd_lat_i = '0;
    logic       rd_cmd_i = 1'b0;
    logic       wr_valid_i = 1'b0;
    logic       drive_en_o;
    logic       drive_sel_o;
    logic       term_en_o;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;   // 50 MHz

    bus_park_sched dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we),
        .cfg_lead_i(cfg_lead_i), .cfg_trail_i(cfg_trail_i), .cfg_rd_lat_i(cfg_rd_lat_i),
        .rd_cmd_i(rd_cmd_i), .wr_valid_i(wr_valid_i),
        .drive_en_o(drive_en_o), .drive_sel_o(drive_sel_o), .term_en_o(term_en_o)
    );

    // {rd, wr, exp drive_en, exp drive_sel, exp term}; expectation is after the edge
    localparam logic [4:0] VEC [16] = '{
        5'b10100, 5'b00100, 5'b01110, 5'b10100,
        5'b00001, 5'b01001, 5'b01001, 5'b00001,
        5'b00001, 5'b00001, 5'b00001, 5'b00001,
        5'b00001, 5'b00110, 5'b00110, 5'b00100
    };

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: {drv,sel,term} actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rd_cmd_i   = 1'b0;
            wr_valid_i = 1'b0;
            cfg_we     = 1'b0;
        end
    endtask

    task automatic load_cfg(input logic [3:0] ld, input logic [3:0] tr, input logic [3:0] lat);
        @(negedge clk);
        cfg_we = 1'b1; cfg_lead_i = ld; cfg_trail_i = tr; cfg_rd_lat_i = lat;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // read at edge E0 (and optional second read at E(second)), check term per edge
    task automatic read_window(input string req, input int first, input int last,
                               input int second, input int first2, input int last2, input int span);
        @(negedge clk);
        rd_cmd_i = 1'b1;
        for (int j = 0; j < span; j++) begin
            @(posedge clk);
            #1;
            begin
                logic t;
                t = (j >= first && j <= last) || (second > 0 && j >= first2 && j <= last2);
                check(req, {drive_en_o, drive_sel_o, term_en_o}, {~t, 1'b0, t});
            end
            @(negedge clk);
            rd_cmd_i = (second > 0 && j + 1 == second);
        end
        rd_cmd_i = 1'b0;
    endtask

    initial begin
        #400000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1 check("R1 in reset", {drive_en_o, drive_sel_o, term_en_o}, 3'b100);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1
        check("R1 after reset", {drive_en_o, drive_sel_o, term_en_o}, 3'b100);

        // R4 R7 R9 R10 R2: table walk with default configuration
        for (int v = 0; v < 16; v++) begin
            @(negedge clk);
            rd_cmd_i   = VEC[v][4];
            wr_valid_i = VEC[v][3];
            @(posedge clk);
            #1 check($sformatf("R4/R7/R9/R10 vector %0d", v),
                     {drive_en_o, drive_sel_o, term_en_o}, VEC[v][2:0]);
        end
        idle(20);

        // R3 R4: single read, defaults, window after E4..E9
        read_window("R3 default window", 4, 9, 0, 0, 0, 14);
        idle(20);

        // R8: two reads 8 apart, gap at E10,E11 parked low
        read_window("R8 separate windows", 4, 9, 8, 12, 17, 20);
        idle(20);

        // R5: lead 3, trail 0 -> E2..E6
        load_cfg(4'd3, 4'd0, 4'd5);
        read_window("R5 new guards", 2, 6, 0, 0, 0, 10);
        idle(20);

        // R6: lead 7 exceeds L=6 -> clipped, window E0..E6
        load_cfg(4'd7, 4'd0, 4'd5);
        read_window("R6 lead clipped", 0, 6, 0, 0, 0, 10);
        idle(20);

        // R5: cfg_we low holds values; drive other fields, repeat R6 window
        @(negedge clk); cfg_lead_i = 4'd1; cfg_trail_i = 4'd9; cfg_rd_lat_i = 4'd12;
        read_window("R5 hold without cfg_we", 0, 6, 0, 0, 0, 10);
        idle(5);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule